// File: doc/BRIEF.md
# Dual-Slot Edge Capture Unit

This block watches an asynchronous event pin and takes a snapshot of a free-running counter value supplied from outside whenever a chosen transition appears on that pin. The pin first passes through a two-flop synchronizer clocked by the timer functional clock. A transition detector then compares the synchronized level with its value one cycle earlier. The counter value present in the detection cycle goes into one of two capture slots.

A small state machine decides where each snapshot goes. It has three states: ARMED, WAIT_SECOND and LOCKED. In single mode the first accepted event moves ARMED to LOCKED (transition ARM_TO_LOCK), fills slot 1 and raises the sticky status flag. In dual mode the first event moves ARMED to WAIT_SECOND (transition ARM_TO_WAIT) and fills slot 1. The second event moves WAIT_SECOND to LOCKED (transition WAIT_TO_LOCK), fills slot 2 and raises the flag. The two timestamps then give the period of a clock wired to the pin.

In LOCKED every event is ignored until software writes the clear strobe. A clear from any state takes the CLEAR_REARM transition back to ARMED. The interrupt line is the status flag gated by an enable.

Top module: `evcap_top`

## Requirements
- R1: After reset both capture slots read 0, the status flag is 0, the interrupt is 0, and the machine is ARMED.
- R2: The 2-bit edge select is encoded as follows: 00 accepts no event, 01 accepts rising transitions, 10 accepts falling transitions, 11 accepts both. With 00 no slot changes.
- R3: Suppose the pin takes a new level before rising clock edge k and holds it. The transition is accepted at edge k+2. The slot then holds the counter input present at edge k+2, and the slot and flag show no change after edges k and k+1.
- R4: In single mode (mode input 0) the first accepted event writes slot 1 and sets the status flag. The flag is sticky. While it is set, further events change neither slot.
- R5: In dual mode (mode input 1) the first accepted event writes slot 1 and leaves the flag at 0. The second writes slot 2 and sets the flag. Later events change nothing until a clear.
- R6: A one-cycle clear strobe drops the flag at the next edge and re-arms capture, so the next accepted event writes slot 1 again. A clear in WAIT_SECOND restarts the sequence. A clear at the same edge as an accepted event wins, and that event is dropped.
- R7: The interrupt output is high exactly when the status flag and the interrupt enable are both high. It follows the enable in the same cycle.
- R8: A pin level held for at least two clock cycles yields exactly one accepted event per transition of the selected kind.
- R9: The mode input is sampled at the first event of a sequence. Once slot 1 has been filled in dual mode, the next event fills slot 2 even if the mode input has meanwhile gone to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 1 | Asynchronous event pin |
| count_i | input | CNT_W (32) | Running counter value to snapshot |
| edge_sel_i | input | 2 | Accepted transition kind (00 none, 01 rise, 10 fall, 11 both) |
| dual_mode_i | input | 1 | 0 single-slot capture, 1 two-slot capture |
| stat_clr_i | input | 1 | Write-1-to-clear strobe for the status flag |
| irq_en_i | input | 1 | Capture interrupt enable |
| cap1_o | output | CNT_W (32) | Capture slot 1 |
| cap2_o | output | CNT_W (32) | Capture slot 2 |
| stat_o | output | 1 | Sticky capture status flag |
| irq_o | output | 1 | Capture interrupt, active high |

## Verification
A pin change driven before clock edge k first shows on the slots and the flag after edge k+2. A clear strobe shows after the very next edge, and the interrupt follows its enable with no register in between. The bench drives every input on the falling edge. It advances a reference model at each rising edge, using the pin levels recorded two and three edges earlier, so the model's latency equals the required one. It compares all outputs at the next falling edge. Directed cases place the pin change and the clear strobe on exact edges to hit the boundaries: the edge k+1 versus k+2 latency, and a clear landing on the same edge as an accepted event.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        ST_ARMED       = 2'd0,
        ST_WAIT_SECOND = 2'd1,
        ST_LOCKED      = 2'd2
    } cap_state_e;

    localparam int unsigned NUM_SLOTS = 2;

endpackage

// File: rtl/evcap_sync.sv
module evcap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic evt_i,
    output logic rise_o,
    output logic fall_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) sync_q[0] <= 1'b0;
                    else         sync_q[0] <= evt_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) sync_q[g] <= 1'b0;
                    else         sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= sync_q[LAST];
    end

    assign rise_o =  sync_q[LAST] & ~prev_q;
    assign fall_o = ~sync_q[LAST] &  prev_q;

    // R8: a single transition never reports both kinds at once
    a_r8_one_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rise_o && fall_o));

    // R8: a rising report is not repeated on the next cycle
    a_r8_no_double_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

endmodule

// File: rtl/evcap_ctrl.sv
module evcap_ctrl
    import evcap_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       rise_i,
    input  logic       fall_i,
    input  logic [1:0] edge_sel_i,
    input  logic       dual_mode_i,
    input  logic       stat_clr_i,
    input  logic       irq_en_i,
    output logic [NUM_SLOTS-1:0] load_o,
    output logic       stat_o,
    output logic       irq_o
);

    cap_state_e state_q, state_d;
    edge_sel_e  sel;
    logic       hit;

    assign sel = edge_sel_e'(edge_sel_i);

    always_comb begin
        unique case (sel)
            EDGE_NONE: hit = 1'b0;
            EDGE_RISE: hit = rise_i;
            EDGE_FALL: hit = fall_i;
            EDGE_BOTH: hit = rise_i | fall_i;
            default:   hit = 1'b0;
        endcase
    end

    // next state: ARM_TO_LOCK, ARM_TO_WAIT, WAIT_TO_LOCK, CLEAR_REARM
    always_comb begin
        state_d = state_q;
        if (stat_clr_i) begin
            state_d = ST_ARMED;
        end else begin
            unique case (state_q)
                ST_ARMED:       if (hit) state_d = dual_mode_i ? ST_WAIT_SECOND : ST_LOCKED;
                ST_WAIT_SECOND: if (hit) state_d = ST_LOCKED;
                ST_LOCKED:      state_d = ST_LOCKED;
                default:        state_d = ST_ARMED;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_ARMED;
        else         state_q <= state_d;
    end

    always_comb begin
        load_o = '0;
        stat_o = 1'b0;
        unique case (state_q)
            ST_ARMED:       load_o[0] = hit & ~stat_clr_i;
            ST_WAIT_SECOND: load_o[1] = hit & ~stat_clr_i;
            ST_LOCKED:      stat_o    = 1'b1;
            default:        load_o    = '0;
        endcase
        irq_o = stat_o & irq_en_i;
    end

    // R6: a clear strobe always returns the machine to ARMED with the flag down
    a_r6_clear_rearms: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_clr_i |=> (state_q == ST_ARMED) && !stat_o);

    // R4: the flag is sticky until cleared
    a_r4_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_o && !stat_clr_i) |=> stat_o);

    // R5: first event in dual mode does not raise the flag
    a_r5_first_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_q == ST_ARMED) && hit && !stat_clr_i && dual_mode_i) |=> !stat_o);

    // R4: the flag only rises after an accepted transition
    a_r4_flag_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(stat_o) |-> $past(rise_i || fall_i));

endmodule

// File: rtl/evcap_store.sv
module evcap_store #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned SLOTS = 2
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [WIDTH-1:0]            value_i,
    input  logic [SLOTS-1:0]            load_i,
    output logic [SLOTS-1:0][WIDTH-1:0] slot_o
);

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)        slot_o[s] <= '0;
                else if (load_i[s]) slot_o[s] <= value_i;
            end
        end
    endgenerate

    // R4: at most one slot is written in any cycle
    a_r4_one_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(load_i));

endmodule

// File: rtl/evcap_top.sv
module evcap_top
    import evcap_pkg::*;
#(
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             evt_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [1:0]       edge_sel_i,
    input  logic             dual_mode_i,
    input  logic             stat_clr_i,
    input  logic             irq_en_i,
    output logic [CNT_W-1:0] cap1_o,
    output logic [CNT_W-1:0] cap2_o,
    output logic             stat_o,
    output logic             irq_o
);

    logic                              rise, fall;
    logic [NUM_SLOTS-1:0]              load;
    logic [NUM_SLOTS-1:0][CNT_W-1:0]   slots;

    evcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .evt_i  (evt_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    evcap_ctrl u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .rise_i      (rise),
        .fall_i      (fall),
        .edge_sel_i  (edge_sel_i),
        .dual_mode_i (dual_mode_i),
        .stat_clr_i  (stat_clr_i),
        .irq_en_i    (irq_en_i),
        .load_o      (load),
        .stat_o      (stat_o),
        .irq_o       (irq_o)
    );

    evcap_store #(.WIDTH(CNT_W), .SLOTS(NUM_SLOTS)) u_store (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .value_i (count_i),
        .load_i  (load),
        .slot_o  (slots)
    );

    assign cap1_o = slots[0];
    assign cap2_o = slots[1];

    // R4: both slots hold while locked and no clear arrives
    a_r4_locked_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_o && !stat_clr_i) |=> ($stable(cap1_o) && $stable(cap2_o)));

    // R2: with no transition kind selected nothing is captured
    a_r2_none_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_sel_i == 2'b00) |=> ($stable(cap1_o) && $stable(cap2_o)));

endmodule

// File: tb/evcap_top_test.sv
module evcap_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt = 1'b0;
    logic [31:0] count = 32'd0;
    logic [1:0]  edge_sel = 2'b00;
    logic        dual = 1'b0;
    logic        clr = 1'b0;
    logic        irq_en = 1'b0;
    logic [31:0] cap1, cap2;
    logic        stat, irq;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    int unsigned cyc = 0;

    // reference model state
    logic        h0 = 0, h1 = 0, h2 = 0, h3 = 0;
    int          mst = 0;
    logic [31:0] m1 = 0, m2 = 0;
    logic [31:0] last_cnt = 0;

    always #10 clk = ~clk;

    evcap_top uut (
        .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .count_i(count),
        .edge_sel_i(edge_sel), .dual_mode_i(dual), .stat_clr_i(clr),
        .irq_en_i(irq_en), .cap1_o(cap1), .cap2_o(cap2), .stat_o(stat), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic accepted(input logic [1:0] sel, input logic now_l, input logic old_l);
        return (sel[0] && now_l && !old_l) || (sel[1] && !now_l && old_l);
    endfunction

    // R3: a level seen at edge m-2 that differs from edge m-3 is acted on at edge m
    task automatic model_edge();
        h3 = h2; h2 = h1; h1 = h0; h0 = evt;
        last_cnt = count;
        if (clr) mst = 0;
        else if (accepted(edge_sel, h2, h3)) begin
            if (mst == 0) begin m1 = count; mst = dual ? 1 : 2; end
            else if (mst == 1) begin m2 = count; mst = 2; end
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        cyc++;
        @(negedge clk);
        chk("R4 slot1", cap1, m1);
        chk("R5 slot2", cap2, m2);
        chk("R6 flag", {31'd0, stat}, {31'd0, mst == 2});
        chk("R7 irq", {31'd0, irq}, {31'd0, (mst == 2) && irq_en});
        count = 32'h1000_0000 + cyc * 7;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_clear();
        clr = 1'b1; step(); clr = 1'b0;
    endtask

    initial begin
        int unsigned seed_v;
        logic [31:0] saved;
        seed_v = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 cap1", cap1, 0);
        chk("R1 cap2", cap2, 0);
        chk("R1 flag", {31'd0, stat}, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        steps(2);

        // R2: edge select 00 ignores both transitions
        evt = 1; steps(4); evt = 0; steps(4);
        chk("R2 none slot1", cap1, 0);
        chk("R2 none flag", {31'd0, stat}, 0);

        // R3 latency and R4 single capture on rising edge
        edge_sel = 2'b01; dual = 0; steps(2);
        evt = 1; step(); step();
        chk("R3 not yet at k+1", {31'd0, stat}, 0);
        chk("R3 slot1 still 0", cap1, 0);
        step();
        chk("R3 value at k+2", cap1, last_cnt);
        chk("R4 flag set", {31'd0, stat}, 1);
        saved = cap1;

        // R4: later events ignored while locked (R8 long levels)
        evt = 0; steps(4); evt = 1; steps(4);
        chk("R4 slot1 held", cap1, saved);
        chk("R4 slot2 untouched", cap2, 0);

        // R7: interrupt follows enable within the cycle
        irq_en = 1; #1;
        chk("R7 irq on", {31'd0, irq}, 1);
        irq_en = 0; #1;
        chk("R7 irq off", {31'd0, irq}, 0);
        irq_en = 1;

        // R6 clear, then R2 falling select
        do_clear();
        chk("R6 flag cleared", {31'd0, stat}, 0);
        chk("R7 irq cleared", {31'd0, irq}, 0);
        edge_sel = 2'b10;
        evt = 0; steps(3);
        chk("R2 falling slot1", cap1, last_cnt);
        chk("R2 falling flag", {31'd0, stat}, 1);

        // R5 dual mode, both edges
        do_clear(); dual = 1; edge_sel = 2'b11; steps(2);
        evt = 1; steps(3);
        chk("R5 first slot1", cap1, last_cnt);
        chk("R5 first no flag", {31'd0, stat}, 0);
        evt = 0; steps(3);
        chk("R5 second slot2", cap2, last_cnt);
        chk("R5 flag after second", {31'd0, stat}, 1);
        saved = cap2;
        evt = 1; steps(3); evt = 0; steps(3);
        chk("R5 locked slot2", cap2, saved);

        // R6: clear at the detection edge wins
        do_clear(); dual = 0; edge_sel = 2'b01; steps(2);
        saved = cap1;
        evt = 1; step(); step();
        clr = 1; step(); clr = 0;
        chk("R6 clear wins flag", {31'd0, stat}, 0);
        chk("R6 clear wins slot1", cap1, saved);
        steps(3);
        chk("R6 event dropped", {31'd0, stat}, 0);

        // R9: mode taken at first event
        evt = 0; steps(2); dual = 1;
        evt = 1; steps(3);
        chk("R9 first slot1", cap1, last_cnt);
        dual = 0; evt = 0; steps(2);
        evt = 1; steps(3);
        chk("R9 second goes to slot2", cap2, last_cnt);
        chk("R9 flag", {31'd0, stat}, 1);

        // constrained random phase, checked by the model in step()
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 4 == 0) evt = ~evt;
            clr = ($urandom % 25 == 0);
            if (i % 200 == 0) begin
                edge_sel = 2'($urandom);
                dual = 1'($urandom);
            end
            if (i % 50 == 0) irq_en = 1'($urandom);
            step();
        end
        clr = 0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule